// File: doc/BRIEF.md
# Programmable Output Clock Selector

This block drives one programmable output clock plus two frame-sync outputs for a line-card timing path. Every timing source enters as a one-cycle enable strobe in a single fast system clock, one strobe for each rising edge of that source. The sources are three PLL-derived clocks (A, B, C) and one frame-rate base strobe. The digital-synthesis clock and the selected reference are plain levels that are already synchronous to the system clock. The output clock is a registered level.

A four-bit frequency code and a decode-mode bit choose the output. In standard mode the code picks a fixed frame rate, the synthesis clock, or a divided copy of PLL A or PLL B. In alternate mode it picks PLL B or PLL C divided by 5, divided by 2 or undivided, or it picks the reference. When the selection changes, the output stays low until the newly chosen clock rises, so no runt pulse appears. The configuration is loaded by a one-cycle load strobe, which is the interface to a register bank outside this block. The two frame-sync outputs, at 8 kHz and 2 kHz, each have their own enable.

Top module: `outclk_sel`

## Requirements
- R1: After reset the stored configuration is code 0000, standard mode, both sync enables set. So `clk_out` is low and both sync outputs run.
- R2: Code 0000 holds `clk_out` low in either decode mode.
- R3: In standard mode, code 0001 outputs the 2 kHz frame clock, which is the base strobe divided by 8. Code 0010 outputs the 8 kHz frame clock, which is the base strobe divided by 2. Code 0011 outputs `synth_clk`, registered once inside the block before the output register.
- R4: In standard mode, codes 0100, 0101, 0110, 0111, 1000, 1001 and 1010 output PLL A divided by 2, 48, 16, 12, 8, 6 and 4.
- R5: In standard mode, codes 1011, 1100, 1101, 1110 and 1111 output PLL B divided by 64, 48, 16, 8 and 4.
- R6: In alternate mode (`cfg_alt`=1), codes 0001, 0010 and 0011 output PLL B divided by 5, divided by 2 and undivided.
- R7: In alternate mode, codes 0100, 0101 and 0110 output PLL C divided by 5, divided by 2 and undivided. Code 0111 outputs `ref_clk`, registered once inside the block.
- R8: In alternate mode, codes 1000 to 1111 hold `clk_out` low.
- R9: A divide-by-N path has a period of N strobes and starts its high phase on the first strobe after reset. An even N gives N/2 strobes high and N/2 low. An odd N gives one strobe more high than low. An undivided path is high for exactly the cycle after each strobe. A strobe or a level change on an input reaches the output on the second clock edge after it is presented.
- R10: `sync_8k` is the base strobe divided by 2 and `sync_2k` is the base strobe divided by 8. Each is gated by its own enable, and a clear enable drives that output low one edge after the enable is stored.
- R11: A load that changes the code or the mode forces `clk_out` low until the first rising edge of the new source. A load that repeats the stored values leaves the output undisturbed.
- R12: The configuration inputs are captured only on a clock edge with `cfg_load` high. At any other time they have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Captures the four configuration inputs |
| cfg_code | input | 4 | Frequency code |
| cfg_alt | input | 1 | Decode mode: 0 standard, 1 alternate |
| cfg_en2k | input | 1 | Enable for the 2 kHz sync output |
| cfg_en8k | input | 1 | Enable for the 8 kHz sync output |
| frm_stb | input | 1 | Frame-rate base strobe (16 kHz) |
| pll_a_stb | input | 1 | PLL A edge strobe |
| pll_b_stb | input | 1 | PLL B edge strobe |
| pll_c_stb | input | 1 | PLL C edge strobe |
| synth_clk | input | 1 | Digital-synthesis clock level |
| ref_clk | input | 1 | Selected reference clock level |
| clk_out | output | 1 | Programmable output clock |
| sync_2k | output | 1 | 2 kHz frame sync |
| sync_8k | output | 1 | 8 kHz frame sync |

## Verification
Each divider counter is shared by every code that uses its ratio. A counter left in the wrong phase therefore shows up as a duty cycle or an edge position off by whole strobes, and it does so within one period of that ratio after the code is selected. A stuck hand-over gate shows up in two ways: the output stays low past the first rising edge of the new source, or it carries a partial pulse right after a load. Either is visible within the first period of the new source. The bench compares all three outputs on every cycle against a behavioural model, sweeping all 32 code and mode pairs with irregular strobe patterns.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int NA = 7;
  localparam int NB = 8;
  localparam int NC = 3;
  localparam int A_RAT [NA] = '{2, 48, 16, 12, 8, 6, 4};
  localparam int B_RAT [NB] = '{64, 48, 16, 8, 4, 5, 2, 1};
  localparam int C_RAT [NC] = '{5, 2, 1};
  localparam int F8_DIV = 2;
  localparam int F2_DIV = 8;

  localparam int IDX_B0  = NA;
  localparam int IDX_C0  = NA + NB;
  localparam int IDX_F8  = IDX_C0 + NC;
  localparam int IDX_F2  = IDX_F8 + 1;
  localparam int IDX_SYN = IDX_F2 + 1;
  localparam int IDX_REF = IDX_SYN + 1;
  localparam int NSEL    = IDX_REF + 1;
  localparam int SEL_W   = $clog2(NSEL + 1);
  localparam int VEC_N   = 2 ** SEL_W;

  function automatic logic [SEL_W-1:0] sel_decode(input logic [3:0] code, input logic alt);
    logic [SEL_W-1:0] s;
    s = SEL_W'(NSEL);
    if (!alt) begin
      case (code)
        4'd0:    s = SEL_W'(NSEL);
        4'd1:    s = SEL_W'(IDX_F2);
        4'd2:    s = SEL_W'(IDX_F8);
        4'd3:    s = SEL_W'(IDX_SYN);
        default: s = SEL_W'(code) - SEL_W'(4);
      endcase
    end else begin
      case (code)
        4'd1:    s = SEL_W'(IDX_B0 + 5);
        4'd2:    s = SEL_W'(IDX_B0 + 6);
        4'd3:    s = SEL_W'(IDX_B0 + 7);
        4'd4:    s = SEL_W'(IDX_C0);
        4'd5:    s = SEL_W'(IDX_C0 + 1);
        4'd6:    s = SEL_W'(IDX_C0 + 2);
        4'd7:    s = SEL_W'(IDX_REF);
        default: s = SEL_W'(NSEL);
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/oc_div.sv
module oc_div #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic lvl,
  output logic rise_nxt
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int HI = (RATIO + 1) / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(RATIO - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (stb) cnt_d = wrap ? '0 : cnt_q + CW'(1);
  end

  generate
    if (RATIO == 1) begin : g_pulse
      always_comb lvl_d = stb;
    end else begin : g_count
      always_comb begin
        lvl_d = lvl_q;
        if (stb) lvl_d = (cnt_d < CW'(HI));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(RATIO - 1);
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl      = lvl_q;
  assign rise_nxt = stb & wrap;
endmodule

// File: rtl/oc_pass.sv
module oc_pass (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise_nxt
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= din;
  end

  assign lvl      = lvl_q;
  assign rise_nxt = din & ~lvl_q;
endmodule

// File: rtl/oc_gate.sv
module oc_gate
  import oc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg,
  input  logic [SEL_W-1:0] sel,
  input  logic [VEC_N-1:0] lvl_vec,
  input  logic [VEC_N-1:0] rise_vec,
  output logic             out
);
  logic armed_q, armed_d;
  logic out_q, out_d;

  always_comb begin
    armed_d = armed_q;
    if (chg)                         armed_d = 1'b0;
    else if (!armed_q && rise_vec[sel]) armed_d = 1'b1;
    out_d = armed_q & lvl_vec[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      out_q   <= out_d;
    end
  end

  assign out = out_q;
endmodule

// File: rtl/outclk_sel.sv
module outclk_sel
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic [3:0] cfg_code,
  input  logic       cfg_alt,
  input  logic       cfg_en2k,
  input  logic       cfg_en8k,
  input  logic       frm_stb,
  input  logic       pll_a_stb,
  input  logic       pll_b_stb,
  input  logic       pll_c_stb,
  input  logic       synth_clk,
  input  logic       ref_clk,
  output logic       clk_out,
  output logic       sync_2k,
  output logic       sync_8k
);
  logic             rst_meta, rst_sync_n;
  logic [3:0]       code_q;
  logic             alt_q, en2_q, en8_q;
  logic             chg;
  logic [SEL_W-1:0] sel;
  logic [VEC_N-1:0] lvl_vec, rise_vec;
  logic             s2_q, s8_q, s2_d, s8_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign chg = cfg_load & ({cfg_alt, cfg_code} != {alt_q, code_q});

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q <= 4'd0;
      alt_q  <= 1'b0;
      en2_q  <= 1'b1;
      en8_q  <= 1'b1;
    end else if (cfg_load) begin
      code_q <= cfg_code;
      alt_q  <= cfg_alt;
      en2_q  <= cfg_en2k;
      en8_q  <= cfg_en8k;
    end
  end

  assign sel = sel_decode(code_q, alt_q);

  for (genvar i = 0; i < NA; i++) begin : g_a
    oc_div #(.RATIO(A_RAT[i])) u_div (
      .clk(clk), .rst_n(rst_sync_n), .stb(pll_a_stb),
      .lvl(lvl_vec[i]), .rise_nxt(rise_vec[i]));
  end
  for (genvar i = 0; i < NB; i++) begin : g_b
    oc_div #(.RATIO(B_RAT[i])) u_div (
      .clk(clk), .rst_n(rst_sync_n), .stb(pll_b_stb),
      .lvl(lvl_vec[IDX_B0+i]), .rise_nxt(rise_vec[IDX_B0+i]));
  end
  for (genvar i = 0; i < NC; i++) begin : g_c
    oc_div #(.RATIO(C_RAT[i])) u_div (
      .clk(clk), .rst_n(rst_sync_n), .stb(pll_c_stb),
      .lvl(lvl_vec[IDX_C0+i]), .rise_nxt(rise_vec[IDX_C0+i]));
  end

  oc_div #(.RATIO(F8_DIV)) u_f8 (
    .clk(clk), .rst_n(rst_sync_n), .stb(frm_stb),
    .lvl(lvl_vec[IDX_F8]), .rise_nxt(rise_vec[IDX_F8]));
  oc_div #(.RATIO(F2_DIV)) u_f2 (
    .clk(clk), .rst_n(rst_sync_n), .stb(frm_stb),
    .lvl(lvl_vec[IDX_F2]), .rise_nxt(rise_vec[IDX_F2]));

  oc_pass u_syn (
    .clk(clk), .rst_n(rst_sync_n), .din(synth_clk),
    .lvl(lvl_vec[IDX_SYN]), .rise_nxt(rise_vec[IDX_SYN]));
  oc_pass u_ref (
    .clk(clk), .rst_n(rst_sync_n), .din(ref_clk),
    .lvl(lvl_vec[IDX_REF]), .rise_nxt(rise_vec[IDX_REF]));

  assign lvl_vec[VEC_N-1:NSEL]  = '0;
  assign rise_vec[VEC_N-1:NSEL] = '0;

  oc_gate u_gate (
    .clk(clk), .rst_n(rst_sync_n), .chg(chg), .sel(sel),
    .lvl_vec(lvl_vec), .rise_vec(rise_vec), .out(clk_out));

  always_comb begin
    s8_d = en8_q & lvl_vec[IDX_F8];
    s2_d = en2_q & lvl_vec[IDX_F2];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_q <= 1'b0;
      s8_q <= 1'b0;
    end else begin
      s2_q <= s2_d;
      s8_q <= s8_d;
    end
  end

  assign sync_2k = s2_q;
  assign sync_8k = s8_q;
endmodule

// File: rtl/outclk_sel_chk.sv
module outclk_sel_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       cfg_load,
  input logic [3:0] cfg_code,
  input logic       cfg_alt,
  input logic [3:0] code_q,
  input logic       alt_q,
  input logic       en2_q,
  input logic       en8_q,
  input logic       clk_out,
  input logic       sync_2k,
  input logic       sync_8k
);
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (code_q == 4'd0) |=> !clk_out); // R2

  AST_UNDEF_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alt_q && code_q[3]) |=> !clk_out); // R8

  AST_SYNC8_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en8_q |=> !sync_8k); // R10

  AST_SYNC2_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en2_q |=> !sync_2k); // R10

  AST_HANDOVER_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_load && ({cfg_alt, cfg_code} != {alt_q, code_q})) |-> ##2 !clk_out); // R11
endmodule

bind outclk_sel outclk_sel_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cfg_load(cfg_load),
  .cfg_code(cfg_code), .cfg_alt(cfg_alt), .code_q(code_q), .alt_q(alt_q),
  .en2_q(en2_q), .en8_q(en8_q), .clk_out(clk_out),
  .sync_2k(sync_2k), .sync_8k(sync_8k));

// File: tb/tb_outclk_sel.sv
module tb_outclk_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic [3:0] cfg_code = 4'd0;
  logic       cfg_alt = 1'b0;
  logic       cfg_en2k = 1'b1;
  logic       cfg_en8k = 1'b1;
  logic       frm_stb = 1'b0;
  logic       pll_a_stb = 1'b0;
  logic       pll_b_stb = 1'b0;
  logic       pll_c_stb = 1'b0;
  logic       synth_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       clk_out, sync_2k, sync_8k;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit active = 1'b0;
  int cyc = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  outclk_sel dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_code(cfg_code),
    .cfg_alt(cfg_alt), .cfg_en2k(cfg_en2k), .cfg_en8k(cfg_en8k),
    .frm_stb(frm_stb), .pll_a_stb(pll_a_stb), .pll_b_stb(pll_b_stb),
    .pll_c_stb(pll_c_stb), .synth_clk(synth_clk), .ref_clk(ref_clk),
    .clk_out(clk_out), .sync_2k(sync_2k), .sync_8k(sync_8k));

  // source: 0 none, 1 A, 2 B, 3 C, 4 frame base, 5 synth, 6 ref
  function automatic void pick(input int code, input bit alt, output int src, output int n);
    int a_tab [7] = '{2, 48, 16, 12, 8, 6, 4};
    int b_tab [5] = '{64, 48, 16, 8, 4};
    int x_tab [3] = '{5, 2, 1};
    src = 0; n = 1;
    if (!alt) begin
      if (code == 1)      begin src = 4; n = 8; end
      else if (code == 2) begin src = 4; n = 2; end
      else if (code == 3) begin src = 5; end
      else if (code >= 4 && code <= 10) begin src = 1; n = a_tab[code-4]; end
      else if (code >= 11) begin src = 2; n = b_tab[code-11]; end
    end else begin
      if (code >= 1 && code <= 3)      begin src = 2; n = x_tab[code-1]; end
      else if (code >= 4 && code <= 6) begin src = 3; n = x_tab[code-4]; end
      else if (code == 7)              begin src = 6; end
    end
  endfunction

  function automatic bit dv(input int k, input int n, input bit pulse);
    if (n == 1) return pulse;
    if (k == 0) return 1'b0;
    return ((k - 1) % n) < ((n + 1) / 2);
  endfunction

  function automatic string req_of(input int code, input bit alt);
    if (code == 0) return "R2";
    if (!alt) return (code <= 3) ? "R3" : (code <= 10) ? "R4 R9" : "R5 R9";
    return (code <= 3) ? "R6 R9" : (code <= 6) ? "R7 R9" : (code == 7) ? "R7" : "R8";
  endfunction

  // behavioural reference model
  int m_code, ka, kb, kc, kf;
  bit m_alt, m_en2, m_en8, m_armed, m_out, m_s2, m_s8;
  bit bq, cq, sq, rq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_alt = 0; m_en2 = 1; m_en8 = 1;
      ka = 0; kb = 0; kc = 0; kf = 0;
      m_armed = 0; m_out = 0; m_s2 = 0; m_s8 = 0;
      bq = 0; cq = 0; sq = 0; rq = 0;
    end else begin
      int src, n;
      bit l, r, chg;
      pick(m_code, m_alt, src, n);
      l = 0; r = 0;
      case (src)
        1: begin l = dv(ka, n, 1'b0); r = pll_a_stb && (ka % n == 0); end
        2: begin l = dv(kb, n, bq);   r = pll_b_stb && (kb % n == 0); end
        3: begin l = dv(kc, n, cq);   r = pll_c_stb && (kc % n == 0); end
        4: begin l = dv(kf, n, 1'b0); r = frm_stb && (kf % n == 0); end
        5: begin l = sq; r = synth_clk && !sq; end
        6: begin l = rq; r = ref_clk && !rq; end
        default: ;
      endcase
      chg = cfg_load && ((int'(cfg_code) != m_code) || (cfg_alt != m_alt));
      m_out = m_armed && l;
      m_armed = chg ? 1'b0 : (m_armed || r);
      m_s8 = m_en8 && dv(kf, 2, 1'b0);
      m_s2 = m_en2 && dv(kf, 8, 1'b0);
      ka += int'(pll_a_stb); kb += int'(pll_b_stb);
      kc += int'(pll_c_stb); kf += int'(frm_stb);
      bq = pll_b_stb; cq = pll_c_stb; sq = synth_clk; rq = ref_clk;
      if (cfg_load) begin
        m_code = int'(cfg_code); m_alt = cfg_alt;
        m_en2 = cfg_en2k; m_en8 = cfg_en8k;
      end
    end
  end

  task automatic check(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle=%0d actual=%0b expected=%0b", req, what, cyc, act, exp);
    end
  endtask

  // one cycle: compare outputs, then drive the next inputs
  task automatic step(input bit load);
    @(negedge clk);
    check(m_armed ? tag : {tag, " R11"}, "clk_out", clk_out, m_out);
    check("R10", "sync_8k", sync_8k, m_s8);
    check("R10", "sync_2k", sync_2k, m_s2);
    cyc++;
    cfg_load  = load;
    frm_stb   = active && (cyc % 5 == 0);
    pll_a_stb = active && (cyc % 2 == 0);
    pll_b_stb = active && (cyc % 3 == 1);
    pll_c_stb = active && ((cyc % 7) < 3);
    synth_clk = active && ((cyc / 3) % 2 == 1);
    ref_clk   = active && ((cyc / 5) % 2 == 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "clk_out in reset", clk_out, 1'b0);
    check("R1", "sync_8k in reset", sync_8k, 1'b0);
    rst_n = 1'b1;
    repeat (4) step(1'b0);
    active = 1'b1;
    tag = "R1";
    repeat (200) step(1'b0);
    // R12: configuration inputs without load have no effect
    tag = "R12";
    cfg_code = 4'd5; cfg_alt = 1'b1; cfg_en2k = 1'b0; cfg_en8k = 1'b0;
    repeat (120) step(1'b0);
    for (int alt = 0; alt < 2; alt++) begin
      for (int code = 0; code < 16; code++) begin
        tag = req_of(code, alt[0]);
        cfg_code = 4'(code); cfg_alt = alt[0];
        cfg_en8k = code[0]; cfg_en2k = code[1];
        step(1'b1);
        repeat (210) step(1'b0);
        // R11: reload of identical values must not disturb clk_out
        step(1'b1);
        repeat (210) step(1'b0);
      end
    end
    // R12: a load of a new code followed by input wiggle without load
    tag = "R4 R12";
    cfg_code = 4'd4; cfg_alt = 1'b0; cfg_en2k = 1'b1; cfg_en8k = 1'b1;
    step(1'b1);
    cfg_code = 4'd0;
    repeat (100) step(1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule